// File: doc/BRIEF.md
# Tiled Region Fence Register Bank

This block holds a bank of fence entries, each describing one page-aligned window of a linear aperture that is to be treated as tiled memory. Software programs an entry through a 32-bit register port as two words: a low word carrying the first page of the window, the row pitch code, the tiling mode and an enable bit, and a high word carrying the last page of the window. Every lookup address is compared in parallel against all armed entries. The block reports whether the address falls in a window, which entry matched, whether that entry uses Y or X tiling, and the row pitch in bytes.

A 64-bit entry cannot be written in one access, so an entry is only live after a low-word write with the enable bit set. Any write to the high word drops the entry out of matching until the low word is written again. The safe update order is: low word to zero, then high word, then low word with the enable bit. Because of this order, a half-updated entry never claims an address. Where windows overlap, the lowest entry index wins.

Top module: `fence_bank`

## Requirements
- R1: After synchronous reset every stored word reads back as zero, no entry is armed and the lookup outputs `hit_o`, `hit_idx`, `hit_ytile`, `hit_pitch` are all zero.
- R2: A read of entry `rd_idx` (`rd_sel_hi`=1 high word, 0 low word) returns on `rd_data` one cycle later exactly the last 32-bit value written to that word. A read in the same cycle as a write to that word returns the old value.
- R3: A lookup with `lk_valid`=1 hits an entry when the entry is armed and low[31:12] <= `lk_addr`[31:12] <= high[31:12]. This means start <= address <= end + 4095. The result appears on the outputs one cycle after the lookup.
- R4: On a hit, `hit_ytile` equals bit 1 of the matching entry's low word (1 = Y tiling, 0 = X tiling). `hit_pitch` equals (low[11:2] + 1) * 128 bytes.
- R5: When several armed entries contain the address, `hit_idx` is the lowest such index, and the tiling and pitch come from that entry.
- R6: A write to the high word of an entry disarms it. The entry matches nothing until a later low-word write with bit 0 set arms it again.
- R7: A low-word write arms the entry when bit 0 of the data is 1. It disarms the entry when bit 0 is 0, so an all-zero low word turns the entry off.
- R8: With `lk_valid`=0 in the lookup cycle, or with no armed entry containing the address, `hit_o`, `hit_idx`, `hit_ytile` and `hit_pitch` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel_hi | input | 1 | Write target: 1 high word, 0 low word |
| cfg_idx | input | IDX_W | Entry written |
| cfg_wdata | input | 32 | Write data |
| rd_idx | input | IDX_W | Entry read back |
| rd_sel_hi | input | 1 | Read target: 1 high word, 0 low word |
| rd_data | output | 32 | Registered readback word |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup byte address |
| hit_o | output | 1 | Registered: address inside an armed entry |
| hit_idx | output | IDX_W | Registered: index of the winning entry |
| hit_ytile | output | 1 | Registered: 1 for Y tiling, 0 for X |
| hit_pitch | output | PITCH_W+8 | Registered: row pitch in bytes |

## Verification
Lookup results and readback words are both due exactly one clock edge after the cycle in which their request is presented. The bench drives each request at a falling edge and samples the outputs at the next falling edge. It compares them with a model of the stored words and arm flags taken before that cycle's write, and only then applies the write to the model. Because of this, a write and a lookup in the same cycle are checked against the pre-write state, which is how the registered hardware behaves. Directed steps cover the window edges, overlap priority, disarm by a high-word write, the full pitch range and an idle lookup. The rest comes from seeded random traffic.

// File: rtl/fence_bank_pkg.sv
package fence_bank_pkg;
  localparam int WORD_W   = 32;
  localparam int PG_SHIFT = 12;
  localparam int PG_W     = WORD_W - PG_SHIFT;
  localparam int PITCH_W  = 10;
  localparam int STRIDE_W = PITCH_W + 8;

  typedef struct packed {
    logic [PG_W-1:0]    first_pg;
    logic [PITCH_W-1:0] pitch_m1;
    logic               ytile;
    logic               enable;
  } low_word_t;

  function automatic logic [STRIDE_W-1:0] pitch_bytes(input logic [PITCH_W-1:0] code);
    logic [STRIDE_W-1:0] n;
    n = STRIDE_W'(code) + STRIDE_W'(1);
    return n << 7;
  endfunction
endpackage

// File: rtl/fence_entry_store.sv
module fence_entry_store #(
  parameter int N_ENT = 32,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic                   sel_hi,
  input  logic [IDX_W-1:0]       idx,
  input  logic [31:0]            wdata,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic                   rd_hi,
  output logic [31:0]            rd_data,
  output logic [N_ENT-1:0][31:0] lo_q,
  output logic [N_ENT-1:0][31:0] hi_q,
  output logic [N_ENT-1:0]       armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      armed <= '0;
    end else if (wr) begin
      if (sel_hi) begin
        hi_q[idx]  <= wdata;
        armed[idx] <= 1'b0;
      end else begin
        lo_q[idx]  <= wdata;
        armed[idx] <= wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_hi ? hi_q[rd_idx] : lo_q[rd_idx];
  end
endmodule

// File: rtl/fence_range_match.sv
module fence_range_match
  import fence_bank_pkg::*;
#(
  parameter int N_ENT = 32
) (
  input  logic [31:0]            addr,
  input  logic [N_ENT-1:0][31:0] lo_q,
  input  logic [N_ENT-1:0][31:0] hi_q,
  input  logic [N_ENT-1:0]       armed,
  output logic [N_ENT-1:0]       hit_vec
);
  logic [PG_W-1:0] addr_pg;
  assign addr_pg = addr[31:PG_SHIFT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic [PG_W-1:0] lo_pg, hi_pg;
    assign lo_pg      = lo_q[g][31:PG_SHIFT];
    assign hi_pg      = hi_q[g][31:PG_SHIFT];
    assign hit_vec[g] = armed[g] && (addr_pg >= lo_pg) && (addr_pg <= hi_pg);
  end
endmodule

// File: rtl/fence_prio_pick.sv
module fence_prio_pick #(
  parameter int N_ENT = 32,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] hit_vec,
  output logic             any,
  output logic [IDX_W-1:0] sel
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/fence_bank.sv
module fence_bank
  import fence_bank_pkg::*;
#(
  parameter int N_ENT = 32,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic                cfg_sel_hi,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [31:0]         cfg_wdata,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                rd_sel_hi,
  output logic [31:0]         rd_data,
  input  logic                lk_valid,
  input  logic [31:0]         lk_addr,
  output logic                hit_o,
  output logic [IDX_W-1:0]    hit_idx,
  output logic                hit_ytile,
  output logic [STRIDE_W-1:0] hit_pitch
);
  logic [N_ENT-1:0][31:0] lo_q, hi_q;
  logic [N_ENT-1:0]       armed_vec;
  logic [N_ENT-1:0]       hit_vec;
  logic                   any_hit;
  logic [IDX_W-1:0]       win_idx;
  low_word_t              win_lo;

  fence_entry_store #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .wr(cfg_wr), .sel_hi(cfg_sel_hi), .idx(cfg_idx),
    .wdata(cfg_wdata), .rd_idx(rd_idx), .rd_hi(rd_sel_hi), .rd_data(rd_data),
    .lo_q(lo_q), .hi_q(hi_q), .armed(armed_vec)
  );

  fence_range_match #(.N_ENT(N_ENT)) u_match (
    .addr(lk_addr), .lo_q(lo_q), .hi_q(hi_q), .armed(armed_vec), .hit_vec(hit_vec)
  );

  fence_prio_pick #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_pick (
    .hit_vec(hit_vec), .any(any_hit), .sel(win_idx)
  );

  assign win_lo = low_word_t'(lo_q[win_idx]);

  always_ff @(posedge clk) begin
    if (rst || !(lk_valid && any_hit)) begin
      hit_o     <= 1'b0;
      hit_idx   <= '0;
      hit_ytile <= 1'b0;
      hit_pitch <= '0;
    end else begin
      hit_o     <= 1'b1;
      hit_idx   <= win_idx;
      hit_ytile <= win_lo.ytile;
      hit_pitch <= pitch_bytes(win_lo.pitch_m1);
    end
  end
endmodule

// File: rtl/fence_bank_chk.sv
module fence_bank_chk
  import fence_bank_pkg::*;
#(
  parameter int N_ENT = 32,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_wr,
  input logic                cfg_sel_hi,
  input logic [IDX_W-1:0]    cfg_idx,
  input logic [31:0]         cfg_wdata,
  input logic                lk_valid,
  input logic                hit_o,
  input logic [IDX_W-1:0]    hit_idx,
  input logic                hit_ytile,
  input logic [STRIDE_W-1:0] hit_pitch,
  input logic [N_ENT-1:0]    armed
);
  logic [N_ENT-1:0] armed_d;
  always_ff @(posedge clk) armed_d <= armed;

  assert_hit_needs_lookup_R3: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(lk_valid));

  assert_idle_outputs_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (hit_idx == '0 && !hit_ytile && hit_pitch == '0));

  assert_pitch_granule_R4: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (hit_pitch[6:0] == 7'd0 && hit_pitch != '0));

  assert_hi_write_disarms_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_sel_hi) |=> !armed[$past(cfg_idx)]);

  assert_lo_write_arms_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_sel_hi) |=> (armed[$past(cfg_idx)] == $past(cfg_wdata[0])));

  assert_winner_was_armed_R5: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> armed_d[hit_idx]);
endmodule

bind fence_bank fence_bank_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel_hi(cfg_sel_hi),
  .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid),
  .hit_o(hit_o), .hit_idx(hit_idx), .hit_ytile(hit_ytile),
  .hit_pitch(hit_pitch), .armed(armed_vec)
);

// File: tb/tb_fence_bank.sv
module tb_fence_bank;
  localparam int N  = 32;
  localparam int IW = $clog2(N);
  localparam int SW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_sel_hi = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [IW-1:0] rd_idx = '0;
  logic rd_sel_hi = 1'b0;
  logic [31:0] rd_data;
  logic lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic hit_o, hit_ytile;
  logic [IW-1:0] hit_idx;
  logic [SW-1:0] hit_pitch;

  always #10 clk = ~clk;

  fence_bank #(.N_ENT(N)) dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel_hi(cfg_sel_hi),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .rd_idx(rd_idx),
    .rd_sel_hi(rd_sel_hi), .rd_data(rd_data), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .hit_o(hit_o), .hit_idx(hit_idx),
    .hit_ytile(hit_ytile), .hit_pitch(hit_pitch)
  );

  int checks = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] lo_m [N];
  logic [31:0] hi_m [N];
  bit          arm_m [N];

  function automatic logic [SW+IW+1:0] expect_hit(input logic lv, input logic [31:0] a);
    for (int i = 0; i < N; i++) begin
      if (lv && arm_m[i] && lo_m[i][31:12] <= a[31:12] && a[31:12] <= hi_m[i][31:12])
        return {1'b1, IW'(i), lo_m[i][1], SW'((SW'(lo_m[i][11:2]) + SW'(1)) * SW'(128))};
    end
    return '0;
  endfunction

  task automatic step(input logic wr, input logic hi, input int idx, input logic [31:0] wd,
                      input logic lv, input logic [31:0] la, input int ridx, input logic rhi,
                      input string tag);
    logic [SW+IW+1:0] exp_h, got_h;
    logic [31:0] exp_rd;
    cfg_wr = wr; cfg_sel_hi = hi; cfg_idx = IW'(idx); cfg_wdata = wd;
    lk_valid = lv; lk_addr = la; rd_idx = IW'(ridx); rd_sel_hi = rhi;
    exp_h  = expect_hit(lv, la);
    exp_rd = rhi ? hi_m[ridx] : lo_m[ridx];
    if (wr) begin
      if (hi) begin hi_m[idx] = wd; arm_m[idx] = 1'b0; end
      else    begin lo_m[idx] = wd; arm_m[idx] = wd[0]; end
    end
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    got_h = {hit_o, hit_idx, hit_ytile, hit_pitch};
    checks++;
    if (got_h !== exp_h) begin
      bad++;
      $display("FAIL %s lookup addr=%h got hit=%b idx=%0d y=%b pitch=%0d expected hit=%b idx=%0d y=%b pitch=%0d",
               tag, la, got_h[SW+IW+1], got_h[SW+IW:SW+1], got_h[SW], got_h[SW-1:0],
               exp_h[SW+IW+1], exp_h[SW+IW:SW+1], exp_h[SW], exp_h[SW-1:0]);
    end
    checks++;
    if (rd_data !== exp_rd) begin
      bad++;
      $display("FAIL R2 readback entry=%0d hi=%b got=%h expected=%h", ridx, rhi, rd_data, exp_rd);
    end
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    step(1'b0, 1'b0, 0, 32'h0, 1'b1, a, 0, 1'b0, tag);
  endtask

  task automatic prog(input int idx, input logic [19:0] fpg, input logic [19:0] lpg,
                      input logic [9:0] pm1, input logic y, input logic [11:0] junk);
    step(1'b1, 1'b0, idx, 32'h0, 1'b0, 32'h0, idx, 1'b0, "R7");
    step(1'b1, 1'b1, idx, {lpg, junk}, 1'b0, 32'h0, idx, 1'b1, "R6");
    step(1'b1, 1'b0, idx, {fpg, pm1, y, 1'b1}, 1'b0, 32'h0, idx, 1'b0, "R7");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin lo_m[i] = '0; hi_m[i] = '0; arm_m[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    checks++;
    if ({hit_o, hit_idx, hit_ytile, hit_pitch} !== '0) begin
      bad++; $display("FAIL R1 outputs after reset got=%h expected=0", {hit_o, hit_idx, hit_ytile, hit_pitch});
    end
    step(1'b0, 1'b0, 0, 0, 1'b1, 32'h0, 0, 1'b0, "R1");
    step(1'b0, 1'b0, 0, 0, 1'b1, 32'h0, N-1, 1'b1, "R1");

    // R3/R4: window edges of entry 3, X tiling, pitch 1024
    prog(3, 20'h10, 20'h13, 10'd7, 1'b0, 12'hABC);
    look(32'h0001_0000, "R3 first byte");
    look(32'h0001_3FFF, "R3 last byte");
    look(32'h0001_4000, "R3 past end");
    look(32'h0000_FFFF, "R3 below start");
    step(1'b0, 1'b0, 0, 0, 1'b0, 0, 3, 1'b1, "R2");

    // R5: overlap, lower index wins; R4 Y tiling, pitch 128
    prog(1, 20'h12, 20'h20, 10'd0, 1'b1, 12'h000);
    look(32'h0001_2345, "R5 overlap");
    look(32'h0001_1000, "R5 only higher");

    // R6: lone high write disarms entry 1
    step(1'b1, 1'b1, 1, 32'h0003_0000, 1'b1, 32'h0001_2000, 1, 1'b1, "R6 same cycle");
    look(32'h0001_2000, "R6 disarmed");
    // R7: zero low word turns entry 3 off
    step(1'b1, 1'b0, 3, 32'h0, 1'b0, 0, 3, 1'b0, "R7");
    look(32'h0001_0000, "R7 cleared");
    // re-arm entry 1, then idle lookup
    step(1'b1, 1'b0, 1, {20'h12, 10'd5, 1'b1, 1'b1}, 1'b0, 0, 1, 1'b1, "R6");
    step(1'b0, 1'b0, 0, 0, 1'b0, 32'h0001_2000, 1, 1'b0, "R8 idle lookup");
    look(32'h0001_2000, "R6 rearmed");
    // R4: largest pitch code on the top entry
    prog(N-1, 20'h100, 20'h100, 10'd1023, 1'b0, 12'hFFF);
    look(32'h0010_0800, "R4 max pitch");
    look(32'h0010_1000, "R8 miss");

    // random traffic
    for (int it = 0; it < 3000; it++) begin
      int r, ix;
      logic [31:0] la;
      logic lv;
      r  = int'($urandom % 8);
      ix = int'($urandom % N);
      la = {12'h0, 8'($urandom % 72), 12'($urandom)};
      lv = ($urandom % 4) != 0;
      if (r < 2) begin
        logic [19:0] f;
        f = 20'($urandom % 64);
        prog(ix, f, f + 20'($urandom % 8), 10'($urandom), 1'($urandom), 12'($urandom));
        step(1'b0, 1'b0, 0, 0, lv, la, ix, 1'($urandom), "R3 R5 random");
      end else if (r == 2) begin
        step(1'b1, 1'b1, ix, $urandom, lv, la, int'($urandom % N), 1'($urandom), "R6 random");
      end else if (r == 3) begin
        step(1'b1, 1'b0, ix, {12'h0, 8'($urandom % 64), 12'($urandom)}, lv, la,
             int'($urandom % N), 1'($urandom), "R7 random");
      end else begin
        step(1'b0, 1'b0, 0, 0, lv, la, int'($urandom % N), 1'($urandom), "R3 R4 R8 random");
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule